// File: doc/BRIEF.md
# Multi-Mode Serial Byte Shifter

The block moves one byte at a time between an 8-bit parallel register and a serial data pin. A paired clock pin carries the shift clock. A 3-bit mode input picks the direction (in or out) and the clock source. The clock can come from a divided rate set by an 8-bit divisor, from the system clock itself, or from an external device driving the clock pin. An eighth mode keeps rotating the loaded byte out of the data pin without end.

A host starts every transfer with a one-cycle access strobe, which stands for a read or write of the shift register's address. With write asserted, the strobe also loads a new byte. Each strobe clears the completion flag and resets the modulo-8 edge counter.

With an internal clock, the block drives the clock pin and stops after eight pulses. With an external clock, the block only counts pulses: it raises the flag every eighth pulse and keeps shifting. Masking the flag into an interrupt is left to the surrounding logic.

Top module: `ser_shifter`

## Requirements
- R1: After reset the register reads 0x00, the flag is low, the clock pin output is high and the data pin output is low.
- R2: The mode codes are: 0 = off, 1 = in at divided rate, 2 = in at system rate, 3 = in on external clock, 4 = looping out at divided rate, 5 = out at divided rate, 6 = out at system rate, 7 = out on external clock. The clock pin is driven (sclk_oe_o = 1) in modes 1, 2, 4, 5 and 6. The data pin is driven (sdata_oe_o = 1) whenever mode bit 2 is set.
- R3: An access strobe clears the flag and the edge counter, and restarts the transfer. It loads wdata_i when wr_i = 1 and leaves the register unchanged when wr_i = 0.
- R4: In the internally clocked modes the generated clock starts high at the access and toggles every H system cycles. H = N+2 in the divided-rate modes, where N is div_i. H = 1 in the system-rate modes.
- R5: In modes 1, 2, 5 and 6 exactly eight rising clock edges are produced. The clock then stays high, and the flag is visible 16·H cycles after the access edge.
- R6: When shifting in, each rising clock edge samples the data pin into bit 0 and moves the older bits one place up. The first bit received ends in bit 7.
- R7: When shifting out, each falling clock edge drives bit 7 onto the data pin and moves the register up one place, filling bit 0 with 0. After a bounded transfer the pin holds the last bit sent, which is the byte's original bit 0.
- R8: In the external modes, a rising edge on sclk_i is acted on in the first system cycle after it is seen, and a falling edge shifts data out. The flag sets on every eighth rising edge, and shifting continues past it.
- R9: In mode 4, bit 7 recirculates into bit 0, so the byte repeats most significant bit first. The clock never stops and the flag never sets.
- R10: In mode 0, pulses on sclk_i have no effect. The register keeps its value, the flag stays low and neither pin is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Transfer mode code |
| div_i | input | DIV_W | Rate divisor N |
| acc_i | input | 1 | Shift register access strobe (read or write) |
| wr_i | input | 1 | Access is a write |
| wdata_i | input | DW | Byte loaded on a write access |
| rdata_o | output | DW | Current register contents |
| done_o | output | 1 | Completion flag |
| sclk_i | input | 1 | Clock pin, input side |
| sclk_o | output | 1 | Clock pin, output side |
| sclk_oe_o | output | 1 | Clock pin output enable |
| sdata_i | input | 1 | Data pin, input side |
| sdata_o | output | 1 | Data pin, output side |
| sdata_oe_o | output | 1 | Data pin output enable |

## Verification
The internal bounded modes are swept over several divisors and byte patterns. The patterns include single set bits at either end, which separate most-significant-first order from least-significant-first order and expose an off-by-one in the bit count. Measuring every clock half-period and the cycle at which the flag appears tells an N+2 divider apart from N+1 or N+3. The external modes run past the eighth pulse and are restarted with a read-only access mid-count, which separates a pulse counter from a stop-after-eight counter. The looping mode and the off mode are checked for a repeated byte and for no effect at all.

// File: rtl/ser_shift_pkg.sv
package ser_shift_pkg;
  typedef enum logic [2:0] {
    SM_OFF      = 3'd0,
    SM_IN_DIV   = 3'd1,
    SM_IN_SYS   = 3'd2,
    SM_IN_EXT   = 3'd3,
    SM_OUT_LOOP = 3'd4,
    SM_OUT_DIV  = 3'd5,
    SM_OUT_SYS  = 3'd6,
    SM_OUT_EXT  = 3'd7
  } sm_mode_e;

  function automatic logic is_ext(input logic [2:0] m);
    return (m == SM_IN_EXT) || (m == SM_OUT_EXT);
  endfunction

  function automatic logic is_int(input logic [2:0] m);
    return (m != SM_OFF) && !is_ext(m);
  endfunction

  function automatic logic is_sys(input logic [2:0] m);
    return (m == SM_IN_SYS) || (m == SM_OUT_SYS);
  endfunction

  function automatic logic is_loop(input logic [2:0] m);
    return m == SM_OUT_LOOP;
  endfunction
endpackage

// File: rtl/sr_clk_gen.sv
module sr_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             sys_rate_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int PH_W = DIV_W + 1;

  logic [PH_W-1:0] ph_q, lim;
  logic            sclk_q, tick;

  // half period is lim+1 cycles
  assign lim  = sys_rate_i ? '0 : PH_W'(div_i) + PH_W'(1);
  assign tick = run_i && !start_i && (ph_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      sclk_q <= 1'b1;
    end else if (start_i) begin
      ph_q   <= '0;
      sclk_q <= 1'b1;
    end else if (run_i) begin
      if (tick) begin
        ph_q   <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        ph_q <= ph_q + PH_W'(1);
      end
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = tick & ~sclk_q;
  assign fall_o = tick & sclk_q;

  // R4
  sclk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i) |=> $stable(sclk_q));
endmodule

// File: rtl/sr_bit_cnt.sv
module sr_bit_cnt #(
  parameter int DW = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic rise_i,
  input  logic flag_en_i,
  output logic wrap_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(DW);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign wrap_o = rise_i && (cnt_q == CNT_W'(DW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (rise_i) begin
      cnt_q <= wrap_o ? '0 : cnt_q + CNT_W'(1);
      if (wrap_o && flag_en_i) done_q <= 1'b1;
    end
  end

  assign done_o = done_q;

  // R5
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(wrap_o && flag_en_i));
  // R3
  clr_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !done_q);
endmodule

// File: rtl/sr_data.sv
module sr_data #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          in_evt_i,
  input  logic          out_evt_i,
  input  logic          recirc_i,
  input  logic          sdata_i,
  output logic [DW-1:0] sr_o,
  output logic          sdata_o
);
  logic [DW-1:0] sr_q;
  logic          sdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      sdata_q <= 1'b0;
    end else if (load_i) begin
      sr_q <= wdata_i;
    end else if (in_evt_i) begin
      sr_q <= {sr_q[DW-2:0], sdata_i};
    end else if (out_evt_i) begin
      sdata_q <= sr_q[DW-1];
      sr_q    <= {sr_q[DW-2:0], recirc_i ? sr_q[DW-1] : 1'b0};
    end
  end

  assign sr_o    = sr_q;
  assign sdata_o = sdata_q;

  // R7
  sdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_evt_i |=> $stable(sdata_q));
  // R6
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_evt_i && !load_i) |=> (sr_q[0] == $past(sdata_i)));
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
  import ser_shift_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             acc_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             done_o,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             sclk_oe_o,
  input  logic             sdata_i,
  output logic             sdata_o,
  output logic             sdata_oe_o
);
  logic ext_m, int_m, sys_m, loop_m, out_m;
  logic active_q, sclk_q;
  logic gen_rise, gen_fall, ext_rise, ext_fall, rise, fall, wrap;

  assign ext_m  = is_ext(mode_i);
  assign int_m  = is_int(mode_i);
  assign sys_m  = is_sys(mode_i);
  assign loop_m = is_loop(mode_i);
  assign out_m  = mode_i[2];

  // external clock edge detect, pin assumed synchronous
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b1;
    else         sclk_q <= sclk_i;
  end

  assign ext_rise = ext_m & sclk_i & ~sclk_q;
  assign ext_fall = ext_m & ~sclk_i & sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  active_q <= 1'b0;
    else if (acc_i)               active_q <= int_m;
    else if (wrap && !loop_m)     active_q <= 1'b0;
    else if (!int_m)              active_q <= 1'b0;
  end

  sr_clk_gen #(.DIV_W(DIV_W)) u_clk_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (acc_i && int_m),
    .run_i      (active_q && int_m),
    .sys_rate_i (sys_m),
    .div_i      (div_i),
    .sclk_o     (sclk_o),
    .rise_o     (gen_rise),
    .fall_o     (gen_fall)
  );

  assign rise = ext_m ? ext_rise : gen_rise;
  assign fall = ext_m ? ext_fall : gen_fall;

  sr_bit_cnt #(.DW(DW)) u_bit_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (acc_i),
    .rise_i    (rise),
    .flag_en_i (!loop_m),
    .wrap_o    (wrap),
    .done_o    (done_o)
  );

  sr_data #(.DW(DW)) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (acc_i && wr_i),
    .wdata_i   (wdata_i),
    .in_evt_i  (rise && !out_m),
    .out_evt_i (fall && out_m),
    .recirc_i  (loop_m),
    .sdata_i   (sdata_i),
    .sr_o      (rdata_o),
    .sdata_o   (sdata_o)
  );

  assign sclk_oe_o  = int_m;
  assign sdata_oe_o = out_m;

  // R9
  loop_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_m && !done_o && !acc_i) |=> !done_o);
  // R5
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !acc_i) |=> $stable(sclk_o));
  // R8
  one_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise, fall}));
  // R10
  off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SM_OFF && !acc_i) |=> $stable(rdata_o));
endmodule

// File: tb/test_ser_shifter.sv
`timescale 1ns/1ps
module test_ser_shifter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [7:0] div = 8'd0;
  logic       acc = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic       sclk_in = 1'b1, sdin = 1'b0;
  logic [7:0] rdata;
  logic       done, sclk_out, sclk_oe, sdout, sdoe;
  int         n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ser_shifter i_ser_shifter (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .div_i(div),
    .acc_i(acc), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .done_o(done),
    .sclk_i(sclk_in), .sclk_o(sclk_out), .sclk_oe_o(sclk_oe),
    .sdata_i(sdin), .sdata_o(sdout), .sdata_oe_o(sdoe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [7:0] d);
    @(negedge clk); acc = 1'b1; wr = w; wdata = d;
    @(negedge clk); acc = 1'b0; wr = 1'b0;
  endtask

  task automatic ext_pulse(input bit b, output bit q);
    @(negedge clk); sdin = b; sclk_in = 1'b0;
    @(negedge clk); sclk_in = 1'b1; q = sdout;
    @(negedge clk);
  endtask

  // bounded internal transfer: modes 1,2,5,6
  task automatic run_int(input logic [2:0] m, input int d, input logic [7:0] pat);
    int h, n, last, per_bad, rises, k, done_at;
    bit prev, outm;
    logic [7:0] got;
    h = (m == 3'd2 || m == 3'd6) ? 1 : d + 2;
    outm = m[2];
    @(negedge clk); mode = m; div = 8'(d); sdin = 1'b0;
    access(1'b1, outm ? pat : 8'h00);
    chk(sclk_out == 1'b1, "R4 clock starts high", sclk_out, 1);
    n = 0; last = 0; per_bad = 0; rises = 0; k = 0; done_at = -1; got = 8'h00;
    prev = sclk_out;
    while (n < 16 * h + 20) begin
      @(negedge clk); n++;
      if (sclk_out != prev) begin
        if (n - last != h) per_bad++;
        last = n;
        if (!sclk_out && !outm && k < 8) begin sdin = pat[7-k]; k++; end
        if (sclk_out) begin rises++; if (outm) got = {got[6:0], sdout}; end
        prev = sclk_out;
      end
      if (done && done_at < 0) done_at = n;
    end
    chk(per_bad == 0, "R4 half period", per_bad, 0);
    chk(rises == 8, "R5 pulse count", rises, 8);
    chk(done_at == 16 * h, "R5 flag timing", done_at, 16 * h);
    chk(sclk_out == 1'b1, "R5 clock idles high", sclk_out, 1);
    if (outm) begin
      chk(got == pat, "R7 msb-first bits", got, pat);
      chk(sdout == pat[0], "R7 pin holds last bit", sdout, pat[0]);
    end else begin
      chk(rdata == pat, "R6 received byte", rdata, pat);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pats [4];
    int   divs [3];
    logic [7:0] pat, got;
    bit   q, saw_done;
    int   rises;
    pats[0] = 8'hA5; pats[1] = 8'h01; pats[2] = 8'h80; pats[3] = 8'h3C;
    divs[0] = 0; divs[1] = 1; divs[2] = 5;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(rdata == 8'h00, "R1 reset register", rdata, 0);
    chk(done == 1'b0, "R1 reset flag", done, 0);
    chk(sclk_out == 1'b1, "R1 reset clock pin", sclk_out, 1);
    chk(sdout == 1'b0, "R1 reset data pin", sdout, 0);

    // R2 direction sweep
    for (int m = 0; m < 8; m++) begin
      @(negedge clk); mode = 3'(m);
      @(negedge clk);
      chk(sclk_oe == (m != 0 && m != 3 && m != 7), "R2 clock pin enable", sclk_oe, (m != 0 && m != 3 && m != 7));
      chk(sdoe == (m >= 4), "R2 data pin enable", sdoe, (m >= 4));
    end

    // R4 R5 R6 R7 sweep over modes, divisors and patterns
    for (int mi = 0; mi < 4; mi++) begin
      for (int di = 0; di < 3; di++) begin
        for (int pi = 0; pi < 4; pi++) begin
          case (mi)
            0: run_int(3'd1, divs[di], pats[pi]);
            1: run_int(3'd2, divs[di], pats[pi]);
            2: run_int(3'd5, divs[di], pats[pi]);
            default: run_int(3'd6, divs[di], pats[pi]);
          endcase
        end
      end
    end

    // R3 restart mid-transfer: the flag timing is measured from the second access
    @(negedge clk); mode = 3'd5; div = 8'd2;
    access(1'b1, 8'hC3);
    repeat (20) @(negedge clk);
    run_int(3'd5, 2, 8'h96);

    // R9 looping output
    @(negedge clk); mode = 3'd4; div = 8'd1;
    access(1'b1, 8'hB1);
    rises = 0; saw_done = 0; q = sclk_out;
    begin
      logic [15:0] seq;
      seq = 16'h0;
      for (int n = 0; n < 16 * 3 * 2 + 10 && rises < 16; n++) begin
        @(negedge clk);
        if (done) saw_done = 1;
        if (sclk_out != q) begin
          if (sclk_out) begin rises++; seq = {seq[14:0], sdout}; end
          q = sclk_out;
        end
      end
      chk(seq == 16'hB1B1, "R9 byte repeats", seq, 16'hB1B1);
      chk(rdata == 8'hB1, "R9 register recirculated", rdata, 8'hB1);
    end
    repeat (40) @(negedge clk) if (done) saw_done = 1;
    chk(!saw_done, "R9 flag never set", saw_done, 0);
    chk(rises == 16, "R9 clock keeps running", rises, 16);

    // R8 external input
    @(negedge clk); mode = 3'd3;
    access(1'b1, 8'h00);
    pat = 8'h6D;
    for (int i = 0; i < 8; i++) begin
      ext_pulse(pat[7-i], q);
      if (i == 6) chk(done == 1'b0, "R8 no flag after 7 pulses", done, 0);
    end
    chk(rdata == pat, "R8 R6 external byte in", rdata, pat);
    chk(done == 1'b1, "R8 flag after 8 pulses", done, 1);
    ext_pulse(1'b1, q); ext_pulse(1'b0, q); ext_pulse(1'b1, q);
    chk(rdata == {pat[4:0], 3'b101}, "R8 shifting continues", rdata, {pat[4:0], 3'b101});
    chk(done == 1'b1, "R8 flag stays set", done, 1);
    // R3 read access: clears flag and counter, keeps data
    access(1'b0, 8'hFF);
    chk(rdata == {pat[4:0], 3'b101}, "R3 read keeps data", rdata, {pat[4:0], 3'b101});
    chk(done == 1'b0, "R3 access clears flag", done, 0);
    for (int i = 0; i < 7; i++) ext_pulse(1'b0, q);
    chk(done == 1'b0, "R3 counter restarted", done, 0);
    ext_pulse(1'b0, q);
    chk(done == 1'b1, "R8 flag after 8 more", done, 1);

    // R8 R7 external output
    @(negedge clk); mode = 3'd7;
    access(1'b1, 8'h4E);
    got = 8'h00;
    for (int i = 0; i < 8; i++) begin
      ext_pulse(1'b0, q);
      got = {got[6:0], q};
    end
    chk(got == 8'h4E, "R8 R7 external byte out", got, 8'h4E);
    chk(done == 1'b1, "R8 out flag", done, 1);

    // R10 off mode
    @(negedge clk); mode = 3'd0;
    access(1'b1, 8'h5A);
    for (int i = 0; i < 10; i++) ext_pulse(1'b1, q);
    chk(rdata == 8'h5A, "R10 register unchanged", rdata, 8'h5A);
    chk(done == 1'b0, "R10 flag low", done, 0);
    chk(!sclk_oe && !sdoe, "R10 pins released", {sclk_oe, sdoe}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule